// File: doc/BRIEF.md
# Active Priority Nesting Tracker

This block keeps the nesting state of one processor interface of an interrupt controller. Each time an interrupt is taken, the block records its preemption level as a single bit in one of two bitmaps, one for each interrupt group. It also sets the running priority to the group priority of that interrupt. Each completion removes the most urgent recorded level of the completing group, and the running priority is then rebuilt from whatever levels are still recorded. No stack of priorities is kept. The nesting depth is bounded only by the number of distinct preemption levels.

The acknowledge side presents the pending interrupt's priority, group and ID. The block answers in the same cycle with the ID, or with the spurious ID 1023 when the interrupt does not preempt. Two binary point registers, a normal one and an aliased one, decide how many low priority bits are ignored when levels are formed. A common-binary-point input selects which of the two a group 1 interrupt uses. The running priority and both bitmaps are outputs, so the surrounding logic can read them.

Top module: `prio_nest_tracker`

## Requirements
- R1: The group priority is the 8-bit priority with bits [bp:0] forced to zero, where bp is the selected binary point. Only bits [7:bp+1] are kept, so a binary point of 7 gives group priority 0.
- R2: A binary point write keeps only write-data bits [2:0]. The stored value is raised to at least 2 for the normal register and at least 3 for the aliased register. After reset the normal register holds 2 and the aliased register holds 3.
- R3: A group 1 acknowledge (group input 1) uses the aliased binary point when the common-binary-point input is 0. Every other acknowledge uses the normal binary point.
- R4: An accepted acknowledge sets bit (group priority >> 3) of the group 0 bitmap when the group input is 0, and of the group 1 bitmap when it is 1.
- R5: An accepted acknowledge makes the running priority equal to the group priority and returns the acknowledge ID in the same cycle.
- R6: An accepted end-of-interrupt clears the lowest set bit of the bitmap of its own group only. The other group's bitmap is left unchanged.
- R7: After an accepted end-of-interrupt, the running priority becomes (index of the lowest set bit of the OR of both bitmaps) << 3. If no bit is set, it becomes 0x100.
- R8: An end-of-interrupt whose ID is at or above the number of implemented interrupts (96 by default, so 96 and 1023 are both ignored) changes nothing. An end-of-interrupt while the running priority is 0x100 also changes nothing.
- R9: An acknowledge whose 8-bit priority is not strictly below the 9-bit running priority is refused. The block returns 1023, and neither the bitmaps nor the running priority change.
- R10: When both strobes arrive in one cycle, the end-of-interrupt takes effect first. The acknowledge is then judged against the running priority that results from it.
- R11: After reset the running priority is 0x100 and both bitmaps are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | 8 | Priority of the interrupt being acknowledged |
| ack_grp | input | 1 | Group of the interrupt being acknowledged |
| ack_id | input | 10 | ID of the interrupt being acknowledged |
| ack_resp_id | output | 10 | ack_id if accepted, 1023 if refused (combinational) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID being completed |
| eoi_grp | input | 1 | Group of the completed interrupt |
| common_bp | input | 1 | 1: group 1 also uses the normal binary point |
| bp_wr | input | 1 | Write strobe, normal binary point |
| abp_wr | input | 1 | Write strobe, aliased binary point |
| bp_wdata | input | 8 | Binary point write data |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| apr_grp0 | output | 32 | Active level bitmap, group 0 |
| apr_grp1 | output | 32 | Active level bitmap, group 1 |
| bp_q | output | 3 | Normal binary point |
| abp_q | output | 3 | Aliased binary point |

## Verification
The running priority and both bitmaps are registered outputs, so any wrong update of the internal state shows at the ports on the clock edge right after the strobe that caused it. A mis-chosen binary point or a wrong mask shows as a wrong run_prio value and a wrong bit position in the same cycle. A wrong clear shows as a surviving or missing bitmap bit. A wrong rebuild shows as a running priority that does not match the lowest set bit. The acknowledge answer is combinational, so a wrong preemption decision is visible in the strobe cycle itself, before any edge.

// File: rtl/pnt_pkg.sv
package pnt_pkg;

  localparam int unsigned BP_W        = 3;
  localparam int unsigned SPURIOUS_ID = 1023;

  typedef enum logic {
    GRP_ZERO = 1'b0,
    GRP_ONE  = 1'b1
  } grp_e;

  function automatic logic [BP_W-1:0] bp_clamp(input logic [BP_W-1:0] raw,
                                                input logic [BP_W-1:0] floor_v);
    return (raw < floor_v) ? floor_v : raw;
  endfunction

endpackage

// File: rtl/pnt_grp_prio.sv
module pnt_grp_prio #(
  parameter int PRIO_W = 8,
  parameter int MIN_BP = 2,
  parameter int LVL_W  = PRIO_W - MIN_BP - 1
) (
  input  logic [PRIO_W-1:0]         prio,
  input  logic [pnt_pkg::BP_W-1:0]  bp,
  output logic [PRIO_W-1:0]         gprio,
  output logic [LVL_W-1:0]          level
);

  // keep only bits strictly above the binary point
  for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
    assign gprio[i] = prio[i] & (int'(bp) < i);
  end

  assign level = gprio[PRIO_W-1 -: LVL_W];

endmodule

// File: rtl/pnt_lsb_find.sv
module pnt_lsb_find #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     onehot
);

  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign onehot = vec & (~vec + W'(1));

endmodule

// File: rtl/pnt_apr_bank.sv
module pnt_apr_bank #(
  parameter int LVL_W  = 5,
  parameter int LEVELS = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              clr_grp,
  input  logic              set_en,
  input  logic              set_grp,
  input  logic [LVL_W-1:0]  set_level,
  output logic [LEVELS-1:0] grp0_q,
  output logic [LEVELS-1:0] grp1_q,
  output logic [LEVELS-1:0] mid_or
);

  import pnt_pkg::*;

  localparam int NGRP = 2;

  logic [NGRP-1:0][LEVELS-1:0] bank_q;
  logic [NGRP-1:0][LEVELS-1:0] bank_mid;
  logic [NGRP-1:0][LEVELS-1:0] bank_d;
  logic [LEVELS-1:0]           low_oh [NGRP];
  logic                        found_unused [NGRP];
  logic [LVL_W-1:0]            idx_unused   [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_find
    pnt_lsb_find #(.W(LEVELS), .IDX_W(LVL_W)) u_find (
      .vec    (bank_q[g]),
      .found  (found_unused[g]),
      .idx    (idx_unused[g]),
      .onehot (low_oh[g])
    );
  end

  // next state: clear of the completing group first, then the new level
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      bank_mid[g] = bank_q[g];
      if (clr_en && (grp_e'(clr_grp) == grp_e'(g))) bank_mid[g] = bank_q[g] & ~low_oh[g];
      bank_d[g] = bank_mid[g];
      if (set_en && (grp_e'(set_grp) == grp_e'(g))) bank_d[g] = bank_mid[g] | (LEVELS'(1) << set_level);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (clr_en || set_en) begin
      bank_q <= bank_d;
    end
  end

  assign grp0_q = bank_q[0];
  assign grp1_q = bank_q[1];
  assign mid_or = bank_mid[0] | bank_mid[1];

endmodule

// File: rtl/prio_nest_tracker.sv
module prio_nest_tracker #(
  parameter int PRIO_W  = 8,
  parameter int MIN_BP  = 2,
  parameter int ID_W    = 10,
  parameter int NUM_IRQ = 96
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_valid,
  input  logic [PRIO_W-1:0]         ack_prio,
  input  logic                      ack_grp,
  input  logic [ID_W-1:0]           ack_id,
  output logic [ID_W-1:0]           ack_resp_id,
  input  logic                      eoi_valid,
  input  logic [ID_W-1:0]           eoi_id,
  input  logic                      eoi_grp,
  input  logic                      common_bp,
  input  logic                      bp_wr,
  input  logic                      abp_wr,
  input  logic [7:0]                bp_wdata,
  output logic [PRIO_W:0]           run_prio,
  output logic [(1<<(PRIO_W-MIN_BP-1))-1:0] apr_grp0,
  output logic [(1<<(PRIO_W-MIN_BP-1))-1:0] apr_grp1,
  output logic [pnt_pkg::BP_W-1:0]  bp_q,
  output logic [pnt_pkg::BP_W-1:0]  abp_q
);

  import pnt_pkg::*;

  localparam int RUN_W  = PRIO_W + 1;
  localparam int LVL_W  = PRIO_W - MIN_BP - 1;
  localparam int LEVELS = 1 << LVL_W;
  localparam logic [RUN_W-1:0] RUN_IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [RUN_W-1:0]  run_q, run_d, run_mid, rebuilt;
  logic              run_en;
  logic [BP_W-1:0]   bp_d, abp_d, bp_sel;
  logic              eoi_ok, ack_ok;
  logic [PRIO_W-1:0] ack_gprio;
  logic [LVL_W-1:0]  ack_level;
  logic [LEVELS-1:0] left_or;
  logic              left_found;
  logic [LVL_W-1:0]  left_idx;
  logic [LEVELS-1:0] left_oh_unused;
  logic [4:0]        wdata_unused;

  assign wdata_unused = bp_wdata[7:3];

  // binary point selection for the acknowledged interrupt
  assign bp_sel = (grp_e'(ack_grp) == GRP_ONE && !common_bp) ? abp_q : bp_q;

  pnt_grp_prio #(.PRIO_W(PRIO_W), .MIN_BP(MIN_BP), .LVL_W(LVL_W)) u_gp (
    .prio  (ack_prio),
    .bp    (bp_sel),
    .gprio (ack_gprio),
    .level (ack_level)
  );

  // completion phase
  assign eoi_ok = eoi_valid && (int'(eoi_id) < NUM_IRQ) && (run_q != RUN_IDLE);

  pnt_lsb_find #(.W(LEVELS), .IDX_W(LVL_W)) u_rebuild (
    .vec    (left_or),
    .found  (left_found),
    .idx    (left_idx),
    .onehot (left_oh_unused)
  );

  assign rebuilt = left_found ? {1'b0, left_idx, {(MIN_BP+1){1'b0}}} : RUN_IDLE;

  always_comb begin
    run_mid = run_q;
    if (eoi_ok) run_mid = rebuilt;
  end

  // acknowledge phase, judged after the completion phase
  assign ack_ok      = ack_valid && ({1'b0, ack_prio} < run_mid);
  assign ack_resp_id = ack_ok ? ack_id : ID_W'(SPURIOUS_ID);

  pnt_apr_bank #(.LVL_W(LVL_W), .LEVELS(LEVELS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_en    (eoi_ok),
    .clr_grp   (eoi_grp),
    .set_en    (ack_ok),
    .set_grp   (ack_grp),
    .set_level (ack_level),
    .grp0_q    (apr_grp0),
    .grp1_q    (apr_grp1),
    .mid_or    (left_or)
  );

  always_comb begin
    run_en = eoi_ok || ack_ok;
    run_d  = run_mid;
    if (ack_ok) run_d = {1'b0, ack_gprio};
    bp_d   = bp_clamp(bp_wdata[BP_W-1:0], BP_W'(MIN_BP));
    abp_d  = bp_clamp(bp_wdata[BP_W-1:0], BP_W'(MIN_BP + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RUN_IDLE;
      bp_q  <= BP_W'(MIN_BP);
      abp_q <= BP_W'(MIN_BP + 1);
    end else begin
      if (run_en) run_q <= run_d;
      if (bp_wr)  bp_q  <= bp_d;
      if (abp_wr) abp_q <= abp_d;
    end
  end

  assign run_prio = run_q;

endmodule

// File: rtl/pnt_checker.sv
module pnt_checker #(
  parameter int PRIO_W  = 8,
  parameter int MIN_BP  = 2,
  parameter int ID_W    = 10,
  parameter int NUM_IRQ = 96,
  parameter int LVL_W   = PRIO_W - MIN_BP - 1,
  parameter int LEVELS  = 1 << LVL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_valid,
  input logic [PRIO_W-1:0] ack_prio,
  input logic [ID_W-1:0]   ack_resp_id,
  input logic              eoi_valid,
  input logic [ID_W-1:0]   eoi_id,
  input logic [PRIO_W:0]   run_prio,
  input logic [LEVELS-1:0] apr_grp0,
  input logic [LEVELS-1:0] apr_grp1,
  input logic [2:0]        bp_q,
  input logic [2:0]        abp_q
);

  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [LEVELS-1:0] act_or, below_mask;
  logic [LVL_W-1:0]  run_lvl;
  logic              solo_ack, ack_wins;

  always_comb begin
    act_or     = apr_grp0 | apr_grp1;
    run_lvl    = run_prio[PRIO_W-1 -: LVL_W];
    below_mask = (LEVELS'(1) << run_lvl) - LEVELS'(1);
    solo_ack   = ack_valid && !eoi_valid;
    ack_wins   = solo_ack && ({1'b0, ack_prio} < run_prio);
  end

  AST_BP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bp_q) >= MIN_BP) && (int'(abp_q) >= MIN_BP + 1)); // R2

  AST_RUN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio != IDLE) |-> (run_prio < IDLE) && (run_prio[MIN_BP:0] == '0)); // R1

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_or == '0) == (run_prio == IDLE))); // R7

  AST_RUN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio != IDLE) |-> act_or[run_lvl] && ((act_or & below_mask) == '0)); // R7

  AST_ACK_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wins |=> ($countones(act_or) == $past($countones(act_or)) + 1)); // R4

  AST_REFUSE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (solo_ack && !ack_wins) |-> (ack_resp_id == ID_W'(1023))); // R9

  AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (solo_ack && !ack_wins) |=> $stable(act_or) && $stable(run_prio)); // R9

  AST_EOI_BADID: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_valid && int'(eoi_id) >= NUM_IRQ)
      |=> $stable(apr_grp0) && $stable(apr_grp1) && $stable(run_prio)); // R8

  AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_valid) |=> ($countones(act_or) <= $past($countones(act_or)))); // R6

endmodule

bind prio_nest_tracker pnt_checker #(
  .PRIO_W(PRIO_W), .MIN_BP(MIN_BP), .ID_W(ID_W), .NUM_IRQ(NUM_IRQ)
) u_pnt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_valid   (ack_valid),
  .ack_prio    (ack_prio),
  .ack_resp_id (ack_resp_id),
  .eoi_valid   (eoi_valid),
  .eoi_id      (eoi_id),
  .run_prio    (run_prio),
  .apr_grp0    (apr_grp0),
  .apr_grp1    (apr_grp1),
  .bp_q        (bp_q),
  .abp_q       (abp_q)
);

// File: tb/prio_nest_tracker_bench.sv
`timescale 1ns/1ps
module prio_nest_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_valid = 1'b0;
  logic [7:0] ack_prio = '0;
  logic       ack_grp = 1'b0;
  logic [9:0] ack_id = '0;
  logic [9:0] ack_resp_id;
  logic       eoi_valid = 1'b0;
  logic [9:0] eoi_id = '0;
  logic       eoi_grp = 1'b0;
  logic       common_bp = 1'b0;
  logic       bp_wr = 1'b0;
  logic       abp_wr = 1'b0;
  logic [7:0] bp_wdata = '0;
  logic [8:0] run_prio;
  logic [31:0] apr_grp0, apr_grp1;
  logic [2:0] bp_q, abp_q;

  prio_nest_tracker u_prio_nest_tracker (
    .clk(clk), .rst_n(rst_n),
    .ack_valid(ack_valid), .ack_prio(ack_prio), .ack_grp(ack_grp), .ack_id(ack_id),
    .ack_resp_id(ack_resp_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .eoi_grp(eoi_grp),
    .common_bp(common_bp), .bp_wr(bp_wr), .abp_wr(abp_wr), .bp_wdata(bp_wdata),
    .run_prio(run_prio), .apr_grp0(apr_grp0), .apr_grp1(apr_grp1),
    .bp_q(bp_q), .abp_q(abp_q)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit reported = 1'b0;

  int          ref_run = 256;
  logic [31:0] ref_g [2];
  int          ref_bp = 2;
  int          ref_abp = 3;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic chk(longint act, longint exp, string req, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int gp_of(int p, int g);
    int bp;
    bp = (g == 1 && !common_bp) ? ref_abp : ref_bp;
    return ((p >> (bp + 1)) << (bp + 1)) & 255;
  endfunction

  function automatic int low_idx(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic model_eoi(int id, int g);
    int i;
    if (id < 96 && ref_run != 256) begin
      i = low_idx(ref_g[g]);
      if (i >= 0) ref_g[g][i] = 1'b0;
      i = low_idx(ref_g[0] | ref_g[1]);
      ref_run = (i < 0) ? 256 : (i << 3);
    end
  endtask

  task automatic check_state(string req);
    chk(run_prio, ref_run, req, "run_prio");
    chk(apr_grp0, ref_g[0], req, "apr_grp0");
    chk(apr_grp1, ref_g[1], req, "apr_grp1");
  endtask

  // acknowledge with an optional simultaneous completion (both==1)
  task automatic strobe(bit do_ack, int p, int g, int aid,
                        bit do_eoi, int eid, int eg, string req);
    int gp;
    bit acc;
    ack_valid = do_ack; ack_prio = 8'(p); ack_grp = g[0]; ack_id = 10'(aid);
    eoi_valid = do_eoi; eoi_id = 10'(eid); eoi_grp = eg[0];
    if (do_eoi) model_eoi(eid, eg);
    #1;
    acc = do_ack && (p < ref_run);
    gp  = gp_of(p, g);
    if (do_ack) chk(ack_resp_id, acc ? aid : 1023, req, "ack_resp_id");
    @(negedge clk);
    ack_valid = 1'b0; eoi_valid = 1'b0;
    if (acc) begin
      ref_g[g][gp >> 3] = 1'b1;
      ref_run = gp;
    end
    check_state(req);
  endtask

  task automatic wr_bp(int v, bit alias_sel, string req);
    bp_wdata = 8'(v); bp_wr = !alias_sel; abp_wr = alias_sel;
    @(negedge clk);
    bp_wr = 1'b0; abp_wr = 1'b0;
    if (alias_sel) begin
      ref_abp = ((v & 7) < 3) ? 3 : (v & 7);
      chk(abp_q, ref_abp, req, "abp_q");
    end else begin
      ref_bp = ((v & 7) < 2) ? 2 : (v & 7);
      chk(bp_q, ref_bp, req, "bp_q");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired before completion");
    report();
  end

  initial begin
    ref_g[0] = '0; ref_g[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R2 reset binary points
    check_state("R11");
    chk(bp_q, 2, "R2", "reset bp_q");
    chk(abp_q, 3, "R2", "reset abp_q");

    // R2 binary point write sweep, upper bits ignored
    for (int v = 0; v < 16; v++) wr_bp(v * 17, 1'b0, "R2");
    for (int v = 0; v < 16; v++) wr_bp(v * 9, 1'b1, "R2");

    // R1/R4/R5 group 0 with every normal binary point
    common_bp = 1'b0;
    wr_bp(3, 1'b1, "R2");
    for (int b = 2; b < 8; b++) begin
      wr_bp(b, 1'b0, "R1");
      for (int p = 0; p < 256; p++) begin
        strobe(1'b1, p, 0, p % 96, 1'b0, 0, 0, "R1");
        strobe(1'b0, 0, 0, 0, 1'b1, p % 96, 0, "R6");
      end
    end
    // R3 group 1 uses the aliased binary point when common_bp is 0
    wr_bp(7, 1'b0, "R3");
    for (int b = 3; b < 8; b++) begin
      wr_bp(b, 1'b1, "R3");
      for (int p = 0; p < 256; p++) begin
        strobe(1'b1, p, 1, 95 - (p % 96), 1'b0, 0, 0, "R3");
        strobe(1'b0, 0, 0, 0, 1'b1, 3, 1, "R7");
      end
    end
    // R3 group 1 uses the normal binary point when common_bp is 1
    common_bp = 1'b1;
    wr_bp(7, 1'b1, "R3");
    for (int b = 2; b < 8; b++) begin
      wr_bp(b, 1'b0, "R3");
      for (int p = 0; p < 256; p += 3) begin
        strobe(1'b1, p, 1, 40, 1'b0, 0, 0, "R3");
        strobe(1'b0, 0, 0, 0, 1'b1, 40, 1, "R7");
      end
    end

    // nesting, refusal boundaries and per-group clearing
    common_bp = 1'b0;
    wr_bp(2, 1'b0, "R2");
    wr_bp(3, 1'b1, "R2");
    strobe(1'b1, 8'hC0, 0, 10, 1'b0, 0, 0, "R4");
    strobe(1'b1, 8'hC5, 1, 11, 1'b0, 0, 0, "R9");
    strobe(1'b1, 8'hC0, 0, 12, 1'b0, 0, 0, "R9");
    strobe(1'b1, 8'hBF, 1, 13, 1'b0, 0, 0, "R5");
    strobe(1'b1, 8'h21, 0, 14, 1'b0, 0, 0, "R5");
    strobe(1'b0, 0, 0, 0, 1'b1, 5, 1, "R6");
    strobe(1'b0, 0, 0, 0, 1'b1, 1023, 0, "R8");
    strobe(1'b0, 0, 0, 0, 1'b1, 96, 0, "R8");
    strobe(1'b0, 0, 0, 0, 1'b1, 95, 0, "R7");
    strobe(1'b0, 0, 0, 0, 1'b1, 0, 0, "R7");
    strobe(1'b0, 0, 0, 0, 1'b1, 0, 0, "R8");
    strobe(1'b1, 8'hFF, 0, 1, 1'b0, 0, 0, "R9");
    strobe(1'b0, 0, 0, 0, 1'b1, 0, 0, "R7");

    // R10 same-cycle completion then acknowledge
    strobe(1'b1, 8'h40, 0, 20, 1'b0, 0, 0, "R10");
    strobe(1'b1, 8'h80, 1, 7, 1'b1, 3, 0, "R10");
    strobe(1'b1, 8'h20, 0, 21, 1'b0, 0, 0, "R10");
    strobe(1'b1, 8'h80, 0, 22, 1'b1, 4, 0, "R10");
    strobe(1'b1, 8'h7F, 0, 23, 1'b1, 1023, 0, "R10");
    strobe(1'b0, 0, 0, 0, 1'b1, 2, 0, "R7");
    strobe(1'b0, 0, 0, 0, 1'b1, 2, 1, "R7");
    strobe(1'b0, 0, 0, 0, 1'b1, 2, 0, "R7");

    report();
  end

endmodule